// File: doc/BRIEF.md
# Metaframe Alignment Supervisor

This block sits behind a block synchronizer on a lane receiver. Each cycle it may receive one 64-bit word with its 2-bit header. The header is 2'b01 for a data word and 2'b10 for a control word. For a control word, bits [63:58] carry the type code. The block looks for the synchronization word and confirms it at the same place in four metaframes in a row before it raises lock. It then watches the scrambler-state slot of every metaframe and gives up alignment after three misses in a row.

The metaframe is `MF_LEN` words long. Position 0 holds the synchronization word (the full 64-bit value `SYNC_WORD`). Position 1 holds the scrambler-state word (type 6'b001010). Position 2 holds a skip word (type 6'b000111). Positions 3 through `MF_LEN-2` hold payload. The last position holds the diagnostic word (type 6'b011001), and bits [33:32] of that word carry the lane status.

All outputs are registered. A word accepted on one clock edge shows its effect after that edge.

Top module: `mframe_lock`

## Requirements
- R1: `mf_lock` rises the cycle after the fourth synchronization word that arrives in four consecutive metaframes, counted `MF_LEN` accepted words apart, while `blk_lock` is high.
- R2: While locked, if the word at position 1 is not a scrambler-state control word three metaframes in a row, `mf_lock` falls after the third such word. A matching word clears the miss count.
- R3: During the search, a word at the expected position 0 that is not the synchronization word discards all matches so far. After a loss of lock, four new synchronization words are needed.
- R4: `mf_start` pulses for one cycle after each word accepted at position 0 while aligned or confirming. It also pulses after a synchronization word that starts a new search.
- R5: While locked, a synchronization word at any position other than 0 pulses `mf_pos_err`.
- R6: While locked, a word at position 0 that is not the synchronization word sets `sync_err` until the next accepted word.
- R7: While locked, a skip control word at a payload position (3 to `MF_LEN-2`) pulses `skip_ins`.
- R8: While locked, a data word (header 2'b01) at position 2 pulses `pyld_ins`. A control word at position 2 that is not a skip word sets `skip_err` until the next accepted word.
- R9: While locked, a word at position `MF_LEN-1` that is not a diagnostic control word sets `diag_err` until the next accepted word.
- R10: `lane_status` takes bits [33:32] of a diagnostic word accepted at position `MF_LEN-1` while locked. It keeps its value otherwise and resets to 0.
- R11: While `blk_lock` is low, `sync_err`, `skip_err` and `diag_err` hold their values and `mf_lock` is 0 from the next cycle on. The three flags update again only on words accepted after `blk_lock` returns.
- R12: Cycles with `wd_valid` low do not advance the metaframe position and produce no `mf_start` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wd_valid | input | 1 | A word is present this cycle |
| wd_hdr | input | 2 | Word header: 01 data, 10 control |
| wd_data | input | 64 | Word payload |
| blk_lock | input | 1 | Upstream block alignment is held |
| mf_lock | output | 1 | Metaframe alignment achieved |
| mf_start | output | 1 | Pulse: a metaframe began |
| mf_pos_err | output | 1 | Pulse: sync word off its position |
| sync_err | output | 1 | Sync slot held a wrong word |
| skip_ins | output | 1 | Pulse: skip word in a payload slot |
| pyld_ins | output | 1 | Pulse: data word in the skip slot |
| skip_err | output | 1 | Skip slot held a wrong control word |
| diag_err | output | 1 | Diagnostic slot held a wrong word |
| lane_status | output | 2 | Last received lane status |

## Verification
The assertions take `blk_lock` and `wd_valid` as free inputs. They assume only that a word's header, payload and valid are sampled together on a single edge. The stimulus keeps every word valid for exactly one cycle and changes inputs only at the falling edge. It builds whole metaframes, inserts at most one corruption per metaframe, and lowers `blk_lock` only between words. Idle gaps are inserted inside one metaframe, so the position counter is exercised with `wd_valid` low.

// File: rtl/mframe_lock.sv
module mframe_lock #(
  parameter int MF_LEN = 8,
  parameter logic [63:0] SYNC_WORD = 64'h78F6_78F6_78F6_78F6,
  parameter int LOCK_CNT = 4,
  parameter int MISS_CNT = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wd_valid,
  input  logic [1:0]  wd_hdr,
  input  logic [63:0] wd_data,
  input  logic        blk_lock,
  output logic        mf_lock,
  output logic        mf_start,
  output logic        mf_pos_err,
  output logic        sync_err,
  output logic        skip_ins,
  output logic        pyld_ins,
  output logic        skip_err,
  output logic        diag_err,
  output logic [1:0]  lane_status
);
  localparam int PW = $clog2(MF_LEN);
  localparam int CW = $clog2(LOCK_CNT + 1);
  localparam int MW = $clog2(MISS_CNT + 1);
  localparam logic [5:0] T_SCR  = 6'b001010;
  localparam logic [5:0] T_SKIP = 6'b000111;
  localparam logic [5:0] T_DIAG = 6'b011001;
  localparam logic [PW-1:0] LAST = PW'(MF_LEN - 1);

  logic [PW-1:0] pos_q;
  logic [CW-1:0] cnt_q;
  logic [MW-1:0] miss_q;

  wire is_ctl  = (wd_hdr == 2'b10);
  wire is_sync = is_ctl && (wd_data == SYNC_WORD);
  wire is_scr  = is_ctl && (wd_data[63:58] == T_SCR);
  wire is_skip = is_ctl && (wd_data[63:58] == T_SKIP);
  wire is_diag = is_ctl && (wd_data[63:58] == T_DIAG);
  wire hunt    = !mf_lock && (cnt_q == '0);
  wire take    = wd_valid && blk_lock;
  wire at_pay  = (pos_q > PW'(2)) && (pos_q < LAST);
  wire [PW-1:0] pos_nxt = (pos_q == LAST) ? '0 : pos_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mf_lock <= 1'b0; pos_q <= '0; cnt_q <= '0; miss_q <= '0;
    end else if (!blk_lock) begin
      mf_lock <= 1'b0; pos_q <= '0; cnt_q <= '0; miss_q <= '0;
    end else if (wd_valid) begin
      if (hunt) begin
        if (is_sync) begin
          cnt_q <= CW'(1);
          pos_q <= PW'(1);
        end
      end else if (!mf_lock) begin
        pos_q <= pos_nxt;
        if (pos_q == '0) begin
          if (!is_sync) cnt_q <= '0;
          else if (cnt_q == CW'(LOCK_CNT - 1)) begin
            mf_lock <= 1'b1;
            cnt_q   <= '0;
            miss_q  <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        pos_q <= pos_nxt;
        if (pos_q == PW'(1)) begin
          if (is_scr) miss_q <= '0;
          else if (miss_q == MW'(MISS_CNT - 1)) begin
            mf_lock <= 1'b0;
            miss_q  <= '0;
            cnt_q   <= '0;
          end else miss_q <= miss_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mf_start <= 1'b0; mf_pos_err <= 1'b0; skip_ins <= 1'b0; pyld_ins <= 1'b0;
      sync_err <= 1'b0; skip_err <= 1'b0; diag_err <= 1'b0; lane_status <= 2'b00;
    end else begin
      mf_start   <= take && (hunt ? is_sync : (pos_q == '0));
      mf_pos_err <= take && mf_lock && (pos_q != '0) && is_sync;
      skip_ins   <= take && mf_lock && at_pay && is_skip;
      pyld_ins   <= take && mf_lock && (pos_q == PW'(2)) && (wd_hdr == 2'b01);
      if (take) begin
        sync_err <= mf_lock && (pos_q == '0) && !is_sync;
        skip_err <= mf_lock && (pos_q == PW'(2)) && !is_skip && (wd_hdr != 2'b01);
        diag_err <= mf_lock && (pos_q == LAST) && !is_diag;
        if (mf_lock && (pos_q == LAST) && is_diag) lane_status <= wd_data[33:32];
      end
    end
  end

  // R1
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mf_lock) |-> $past(wd_valid && blk_lock && wd_hdr == 2'b10 && wd_data == SYNC_WORD));
  // R2
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mf_lock) |-> $past(!blk_lock || (wd_valid && !(wd_hdr == 2'b10 && wd_data[63:58] == T_SCR))));
  // R11
  blk_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_lock |=> !mf_lock);
  // R11
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_lock |=> $stable(sync_err));
  // R11
  skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_lock |=> $stable(skip_err));
  // R11
  diag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_lock |=> ($stable(diag_err) && $stable(lane_status)));
  // R12
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_valid |=> !mf_start);
  // R8
  skip_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({skip_ins, pyld_ins, skip_err}));
endmodule

// File: tb/mframe_lock_tb.sv
module mframe_lock_tb;
  localparam int MF = 8;
  localparam logic [63:0] SYNC = 64'h78F6_78F6_78F6_78F6;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, wd_valid, blk_lock;
  logic [1:0] wd_hdr;
  logic [63:0] wd_data;
  logic mf_lock, mf_start, mf_pos_err, sync_err, skip_ins, pyld_ins, skip_err, diag_err;
  logic [1:0] lane_status;

  mframe_lock #(.MF_LEN(MF)) u_dut (
    .clk(clk), .rst_n(rst_n), .wd_valid(wd_valid), .wd_hdr(wd_hdr), .wd_data(wd_data),
    .blk_lock(blk_lock), .mf_lock(mf_lock), .mf_start(mf_start), .mf_pos_err(mf_pos_err),
    .sync_err(sync_err), .skip_ins(skip_ins), .pyld_ins(pyld_ins), .skip_err(skip_err),
    .diag_err(diag_err), .lane_status(lane_status));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ctl(input logic [5:0] t, input logic [1:0] st);
    return {t, 58'h0} | ({62'h0, st} << 32);
  endfunction

  task automatic put(input logic [1:0] h, input logic [63:0] d, input int gap);
    for (int g = 0; g < gap; g++) begin
      wd_valid = 1'b0;
      @(negedge clk);
    end
    wd_valid = 1'b1; wd_hdr = h; wd_data = d;
    @(negedge clk);
    wd_valid = 1'b0;
  endtask

  // flag index: 1 mf_pos_err, 2 sync_err, 3 skip_ins, 4 pyld_ins, 5 skip_err, 6 diag_err
  task automatic send_mf(input int bad_pos, input logic [1:0] bh, input logic [63:0] bd,
                         input int fidx, input int lk_on, input int lk_off,
                         input logic [1:0] st, input bit chk_st, input int gap, input string req);
    for (int p = 0; p < MF; p++) begin
      logic [1:0] h;
      logic [63:0] d;
      logic [5:0] ef;
      if (p == 0) begin h = 2'b10; d = SYNC; end
      else if (p == 1) begin h = 2'b10; d = ctl(6'b001010, 2'b00) | 64'h5A5A; end
      else if (p == 2) begin h = 2'b10; d = ctl(6'b000111, 2'b00); end
      else if (p == MF - 1) begin h = 2'b10; d = ctl(6'b011001, st); end
      else begin h = 2'b01; d = 64'h1234_0000_0000_0000 + 64'(p); end
      if (p == bad_pos) begin h = bh; d = bd; end
      put(h, d, gap);
      check(req, mf_lock, ((p >= lk_on) && (p < lk_off)) ? 64'd1 : 64'd0);
      if (bad_pos != 0) check("R4 frame start", mf_start, (p == 0) ? 64'd1 : 64'd0);
      ef = (p == bad_pos && fidx > 0) ? (6'b1 << (fidx - 1)) : 6'b0;
      check({req, " flags R5-R9"}, {diag_err, skip_err, pyld_ins, skip_ins, sync_err, mf_pos_err}, ef);
      if (chk_st && p == MF - 1) check("R10 lane status", lane_status, st);
    end
  endtask

  localparam logic [63:0] DW = 64'hCAFE_0000_0000_0001;

  initial begin
    rst_n = 1'b0; wd_valid = 1'b0; blk_lock = 1'b0; wd_hdr = 2'b00; wd_data = '0;
    repeat (3) @(negedge clk);
    check("R1 reset lock", mf_lock, 0);
    check("R4 reset start", mf_start, 0);
    check("R10 reset status", lane_status, 0);
    rst_n = 1'b1; blk_lock = 1'b1;
    @(negedge clk);
    // R1: three metaframes leave lock low, fourth raises it after its sync word
    for (int m = 0; m < 3; m++) send_mf(-1, 2'b00, 0, 0, MF, MF, 2'b11, 0, 0, "R1");
    check("R10 unlocked diag ignored", lane_status, 0);
    send_mf(-1, 2'b00, 0, 0, 0, MF, 2'b10, 1, 0, "R1");
    // R12: idle gaps between words
    send_mf(-1, 2'b00, 0, 0, 0, MF, 2'b01, 1, 2, "R12");
    send_mf(0, 2'b01, DW, 2, 0, MF, 2'b01, 1, 0, "R6");
    send_mf(4, 2'b10, SYNC, 1, 0, MF, 2'b01, 1, 0, "R5");
    send_mf(5, 2'b10, ctl(6'b000111, 0), 3, 0, MF, 2'b01, 1, 0, "R7");
    send_mf(2, 2'b01, DW, 4, 0, MF, 2'b01, 1, 0, "R8");
    send_mf(2, 2'b10, ctl(6'b011001, 0), 5, 0, MF, 2'b01, 1, 0, "R8");
    send_mf(MF - 1, 2'b01, DW, 6, 0, MF, 2'b01, 0, 0, "R9");
    check("R10 status kept", lane_status, 2'b01);
    // R2: two misses then a match keep lock; three misses drop it
    send_mf(1, 2'b01, DW, 0, 0, MF, 2'b01, 1, 0, "R2");
    send_mf(1, 2'b01, DW, 0, 0, MF, 2'b01, 1, 0, "R2");
    send_mf(-1, 2'b00, 0, 0, 0, MF, 2'b01, 1, 0, "R2");
    send_mf(1, 2'b01, DW, 0, 0, MF, 2'b01, 1, 0, "R2");
    send_mf(1, 2'b01, DW, 0, 0, MF, 2'b01, 1, 0, "R2");
    send_mf(1, 2'b01, DW, 0, 0, 1, 2'b11, 0, 0, "R2");
    check("R10 status after loss", lane_status, 2'b01);
    // R3: relock needs four fresh sync words
    for (int m = 0; m < 3; m++) send_mf(-1, 2'b00, 0, 0, MF, MF, 2'b00, 0, 0, "R3");
    send_mf(-1, 2'b00, 0, 0, 0, MF, 2'b10, 1, 0, "R3");
    // R11: held flags while block lock is lost
    put(2'b01, DW, 0);
    check("R11 sync_err set", sync_err, 1);
    blk_lock = 1'b0;
    for (int k = 0; k < 3; k++) begin
      put(2'b01, DW, 1);
      check("R11 sync_err held", sync_err, 1);
      check("R11 lock dropped", mf_lock, 0);
    end
    blk_lock = 1'b1;
    @(negedge clk);
    check("R11 sync_err held until word", sync_err, 1);
    put(2'b01, DW, 0);
    check("R11 sync_err updates", sync_err, 0);
    // R3: mismatch during confirmation restarts the count
    send_mf(-1, 2'b00, 0, 0, MF, MF, 2'b00, 0, 0, "R3");
    send_mf(-1, 2'b00, 0, 0, MF, MF, 2'b00, 0, 0, "R3");
    send_mf(0, 2'b01, DW, 0, MF, MF, 2'b00, 0, 0, "R3");
    for (int m = 0; m < 3; m++) send_mf(-1, 2'b00, 0, 0, MF, MF, 2'b00, 0, 0, "R3");
    send_mf(-1, 2'b00, 0, 0, 0, MF, 2'b11, 1, 0, "R3");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule